// File: doc/BRIEF.md
# I2C Slave Write Receiver with DMA Hand-off

This block is the receive side of an I2C slave. It watches the bus lines through synchronizers clocked by a faster system clock. It spots START, repeated START and STOP conditions and compares the first byte after a START with its own 7-bit address. It acknowledges the address when that address matches and asks for a write. It then acknowledges every data byte that follows. It never drives data onto the bus. Master-read transfers are not supported.

The CPU handles only the events that open and close a transfer. After an address match, the block raises an interrupt and a START flag, and gives a one-cycle wake pulse for a sleep controller. It then holds SCL low until software clears the interrupt. A STOP raises the interrupt and a STOP flag, and it does not hold the clock.

Data bytes do not involve the CPU. Each finished byte is placed on a data register and raises a DMA request. The block stretches SCL until the DMA engine acknowledges. That acknowledge both drops the request and lets the bus run again. A master can chain transfers with a repeated START, and the block treats each new write address exactly like the first one.

Top module: `i2c_dma_slave_rx`

## Requirements
- R1: After reset, all outputs are low: `irq_o`, both flags, `wake_o`, `dma_req_o`, `scl_hold_o`, `sda_ack_o`, and `rx_byte_o` = 0.
- R2: After a START, a first byte equal to `{dev_addr_i, 1'b0}` is acknowledged. SDA is pulled low for the 9th clock. On the 9th SCL falling edge, `irq_o` and `start_flag_o` are set and `wake_o` pulses high for exactly one cycle.
- R3: After a matched address, `scl_hold_o` stays high until `irq_clr_i` is pulsed. It is then released, and `irq_o` falls.
- R4: Bits are shifted in MSB first on SCL rising edges. Each data byte after a matched address is acknowledged. On its 9th SCL falling edge, `rx_byte_o` takes the byte and `dma_req_o` rises, with no change to `irq_o`.
- R5: While `dma_req_o` is high, SCL is held low and `rx_byte_o` does not change. A `dma_ack_i` pulse drops both the request and the hold.
- R6: A repeated START followed by a matched write address behaves as in R2 and R3: the ACK, the interrupt, the START flag, the wake pulse, and the hold until cleared.
- R7: A STOP seen after a matched address sets `stop_flag_o` and `irq_o` without holding SCL. `stop_clr_i` clears the flag and `irq_o` is cleared by `irq_clr_i`.
- R8: `start_flag_o` stays set through `irq_clr_i` and bus traffic. Only `start_clr_i` clears it.
- R9: An address byte that mismatches, or has the read bit (LSB = 1), is not acknowledged. Until the next START, later bytes are not acknowledged and raise no interrupt, wake, DMA request or STOP flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_hold_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_ack_o | output | 1 | 1 pulls SDA low (acknowledge) |
| dev_addr_i | input | 7 | Own 7-bit slave address |
| irq_o | output | 1 | CPU interrupt flag |
| start_flag_o | output | 1 | Address-match status flag |
| stop_flag_o | output | 1 | STOP status flag |
| irq_clr_i | input | 1 | Clears the interrupt and any address hold |
| start_clr_i | input | 1 | Clears the START flag |
| stop_clr_i | input | 1 | Clears the STOP flag |
| wake_o | output | 1 | One-cycle pulse on a matched write address |
| dma_req_o | output | 1 | A received byte is ready |
| dma_ack_i | input | 1 | DMA has taken the byte |
| rx_byte_o | output | 8 | Last received data byte |

## Verification
The in-module assertions check the cycle-level rules on every cycle. The wake output never lasts two cycles. A DMA request persists until its acknowledge and falls right after it. The data register is frozen while a request waits. The START flag survives until its own clear. Every interrupt rising edge comes with a status flag. Only the bench scenarios can show the protocol-level behaviour. Those cover address matching against the wired bus, the MSB-first byte order, the ACK level seen by the master, stretching that lasts until the right party responds, repeated-START re-entry, and silence after a mismatched or read address.

// File: rtl/i2c_dma_slave_rx.sv
module i2c_dma_slave_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_hold_o,
  output logic       sda_ack_o,
  input  logic [6:0] dev_addr_i,
  output logic       irq_o,
  output logic       start_flag_o,
  output logic       stop_flag_o,
  input  logic       irq_clr_i,
  input  logic       start_clr_i,
  input  logic       stop_clr_i,
  output logic       wake_o,
  output logic       dma_req_o,
  input  logic       dma_ack_i,
  output logic [7:0] rx_byte_o
);

  typedef enum logic [1:0] {IDLE, ADDR, DATA} phase_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  phase_t phase;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic in_ack, hold_cpu, addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign addr_hit  = (shreg[7:1] == dev_addr_i) & ~shreg[0];
  assign scl_hold_o = hold_cpu | dma_req_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= IDLE;
      shreg        <= '0;
      cnt          <= '0;
      in_ack       <= 1'b0;
      sda_ack_o    <= 1'b0;
      hold_cpu     <= 1'b0;
      irq_o        <= 1'b0;
      start_flag_o <= 1'b0;
      stop_flag_o  <= 1'b0;
      wake_o       <= 1'b0;
      dma_req_o    <= 1'b0;
      rx_byte_o    <= '0;
    end else begin
      wake_o <= 1'b0;
      if (irq_clr_i) begin
        irq_o    <= 1'b0;
        hold_cpu <= 1'b0;
      end
      if (start_clr_i) start_flag_o <= 1'b0;
      if (stop_clr_i)  stop_flag_o  <= 1'b0;
      if (dma_ack_i)   dma_req_o    <= 1'b0;

      if (start_det) begin
        phase     <= ADDR;
        cnt       <= '0;
        in_ack    <= 1'b0;
        sda_ack_o <= 1'b0;
      end else if (stop_det) begin
        if (phase == DATA) begin
          stop_flag_o <= 1'b1;
          irq_o       <= 1'b1;
        end
        phase     <= IDLE;
        cnt       <= '0;
        in_ack    <= 1'b0;
        sda_ack_o <= 1'b0;
      end else if (phase != IDLE) begin
        if (scl_rise && !in_ack && cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 4'd1;
        end else if (scl_fall && !in_ack && cnt == 4'd8) begin
          if (phase == DATA || addr_hit) begin
            sda_ack_o <= 1'b1;
            in_ack    <= 1'b1;
          end else begin
            phase <= IDLE;
          end
        end else if (scl_fall && in_ack) begin
          sda_ack_o <= 1'b0;
          in_ack    <= 1'b0;
          cnt       <= '0;
          if (phase == ADDR) begin
            phase        <= DATA;
            irq_o        <= 1'b1;
            start_flag_o <= 1'b1;
            wake_o       <= 1'b1;
            hold_cpu     <= 1'b1;
          end else begin
            rx_byte_o <= shreg;
            dma_req_o <= 1'b1;
          end
        end
      end
    end
  end

  // R2
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R5
  req_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !dma_ack_i) |=> dma_req_o);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack_i |=> !dma_req_o);

  // R5
  byte_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !dma_ack_i) |=> $stable(rx_byte_o));

  // R8
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag_o && !start_clr_i) |=> start_flag_o);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (start_flag_o || stop_flag_o));

endmodule

// File: tb/test_i2c_dma_slave_rx.sv
module test_i2c_dma_slave_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] dev_addr = 7'h5A;
  logic irq_clr = 0, start_clr = 0, stop_clr = 0, dma_ack = 0;
  logic scl_hold, sda_ack, irq, start_flag, stop_flag, wake, dma_req;
  logic [7:0] rx_byte;
  wire scl = scl_m & ~scl_hold;
  wire sda = sda_m & ~sda_ack;
  int tests = 0, fails = 0, wake_cnt = 0;
  bit done = 0;
  localparam int HALF = 20;
  localparam int Q = 10;

  always #2.5 clk = ~clk;

  i2c_dma_slave_rx i_i2c_dma_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_hold_o(scl_hold), .sda_ack_o(sda_ack), .dev_addr_i(dev_addr),
    .irq_o(irq), .start_flag_o(start_flag), .stop_flag_o(stop_flag),
    .irq_clr_i(irq_clr), .start_clr_i(start_clr), .stop_clr_i(stop_clr),
    .wake_o(wake), .dma_req_o(dma_req), .dma_ack_i(dma_ack), .rx_byte_o(rx_byte));

  always @(posedge clk) if (wake) wake_cnt++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    while (scl !== 1'b1) tick(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl_high(); tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_scl_high(); tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ackbit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; wait_scl_high(); tick(HALF);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl_high(); tick(HALF / 2);
    ackbit = sda;
    tick(HALF / 2);
    scl_m = 1'b0;
    tick(8);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1", "irq", irq, 0);
    chk("R1", "flags", {start_flag, stop_flag}, 0);
    chk("R1", "wake/req", {wake, dma_req}, 0);
    chk("R1", "bus drive", {scl_hold, sda_ack}, 0);
    chk("R1", "rx_byte", rx_byte, 0);
  endtask

  task automatic addr_phase(string req);
    logic a;
    int w0 = wake_cnt;
    send_byte({dev_addr, 1'b0}, a);
    chk(req, "addr ack", a, 0);
    chk(req, "irq", irq, 1);
    chk(req, "start flag", start_flag, 1);
    chk(req, "wake pulses", wake_cnt - w0, 1);
    tick(40);
    chk(req, "hold before clear", scl_hold, 1);
    pulse(irq_clr);
    chk(req, "hold after clear", scl_hold, 0);
    chk(req, "irq after clear", irq, 0);
  endtask

  task automatic data_byte(logic [7:0] b);
    logic a;
    logic [7:0] seen;
    send_byte(b, a);
    chk("R4", "data ack", a, 0);
    chk("R4", "dma_req", dma_req, 1);
    chk("R4", "rx_byte", rx_byte, b);
    chk("R4", "no irq", irq, 0);
    seen = rx_byte;
    tick(30);
    chk("R5", "hold while req", scl_hold, 1);
    chk("R5", "byte stable", rx_byte, seen);
    pulse(dma_ack);
    chk("R5", "req after ack", dma_req, 0);
    chk("R5", "hold after ack", scl_hold, 0);
  endtask

  task automatic t_write_burst();
    bus_start();
    addr_phase("R2");
    chk("R3", "hold released", scl_hold, 0);
    chk("R8", "start kept after irq clear", start_flag, 1);
    data_byte(8'hA5);
    data_byte(8'h3C);
    chk("R8", "start kept over data", start_flag, 1);
    pulse(start_clr);
    chk("R8", "start cleared", start_flag, 0);
  endtask

  task automatic t_restart_stop();
    bus_start();
    addr_phase("R6");
    data_byte(8'h01);
    bus_stop();
    tick(8);
    chk("R7", "stop flag", stop_flag, 1);
    chk("R7", "irq on stop", irq, 1);
    chk("R7", "no hold on stop", scl_hold, 0);
    pulse(stop_clr);
    chk("R7", "stop cleared", stop_flag, 0);
    pulse(irq_clr);
    chk("R7", "irq cleared", irq, 0);
    pulse(start_clr);
  endtask

  task automatic t_ignore(logic [7:0] first, string what);
    logic a;
    int w0 = wake_cnt;
    bus_start();
    send_byte(first, a);
    chk("R9", {what, " nack"}, a, 1);
    chk("R9", {what, " no irq"}, {irq, start_flag}, 0);
    chk("R9", {what, " no wake"}, wake_cnt - w0, 0);
    send_byte(8'h77, a);
    chk("R9", {what, " data nack"}, a, 1);
    chk("R9", {what, " no req/hold"}, {dma_req, scl_hold}, 0);
    bus_stop();
    tick(8);
    chk("R9", {what, " no stop"}, {stop_flag, irq}, 0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_burst();
    t_restart_stop();
    t_ignore({7'h3B, 1'b0}, "mismatch");
    t_ignore({dev_addr, 1'b1}, "read");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule